// File: doc/BRIEF.md
# Write-Through Byte Cache

This block is a small fully associative data cache. It sits between a processor's byte load/store port and a slower backing memory. Stores are write-through with allocation. Any miss, on a load or on a store, fetches the full two-byte block from memory and installs it before the access finishes. Every store updates the cached byte and also sends exactly that one byte to memory. Memory therefore always agrees with the cache, and replacing a line never causes a memory write.

The processor hands over one request at a time with a valid/ready handshake. It receives a single-cycle response pulse that carries the read byte. The memory side has two channels. The block-read channel has a request handshake and a later data-return pulse. The byte-write channel is a posted valid/ready handshake. Two counters record how many completed accesses hit and how many missed.

Top module: `wt_cache`

## Requirements
- R1: After reset, `cpu_req_ready` is high, both counters read zero, no memory request is raised, and every line is invalid, so the first access of any address misses.
- R2: A byte address splits into a tag (all bits above bit 0) and a block offset (bit 0). After a block is installed, an access to either byte of that block hits.
- R3: On a miss, exactly one block read is issued with `mem_rd_addr` equal to the tag. The returned block's low byte is offset 0 and its high byte is offset 1. The request holds stable until accepted, and the access completes only after the block has been installed.
- R4: A store that misses allocates the line, so a later load of either byte in that block hits.
- R5: Every store, whether it hits or misses, issues exactly one memory write carrying the full byte address and the stored byte. The write holds stable until accepted. The store's response echoes the stored byte, and later loads of that address return it.
- R6: Loads never write memory, and evicting a line issues no memory write.
- R7: The line that is filled is the lowest-numbered invalid line if one exists. Otherwise it is the least recently used line, where recency is updated on every hit and every fill.
- R8: Each completed access increments exactly one counter, the hit counter or the miss counter, one cycle after its response pulse. At all other times both counters hold.
- R9: `cpu_req_ready` is low from the acceptance of a request until its response. Each request gets exactly one single-cycle `cpu_rsp_valid` pulse.
- R10: A load hit completes without any memory read or memory write and returns the cached byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W (5) | Byte address |
| cpu_wdata | input | DATA_W (8) | Store byte |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W (8) | Loaded byte, or the stored byte for a store |
| mem_rd_valid | output | 1 | Block read request |
| mem_rd_ready | input | 1 | Memory accepts the block read |
| mem_rd_addr | output | ADDR_W-OFF_W (4) | Block address (tag) |
| mem_rd_rvalid | input | 1 | Block data returned this cycle |
| mem_rd_data | input | 2^OFF_W*DATA_W (16) | Block data, offset 0 in the low byte |
| mem_wr_valid | output | 1 | Byte write request |
| mem_wr_ready | input | 1 | Memory accepts the byte write |
| mem_wr_addr | output | ADDR_W (5) | Byte write address |
| mem_wr_data | output | DATA_W (8) | Byte write data |
| hit_count | output | CNT_W (16) | Completed hits |
| miss_count | output | CNT_W (16) | Completed misses |

## Verification
The bench builds the block at its default parameters: a 5-bit address, bytes of 8 bits, a 1-bit offset and 16-bit counters. Those values give a 16-block address space over two lines. With that much more blocks than lines, random traffic evicts often, and every replacement choice shows up in whether a later access hits or misses. The memory model inserts random ready stalls and return delays. That exercises the holding of both memory requests and the blocking of the processor port, while directed sequences cover the neighbour-byte hit, store allocation and eviction of the least recently used line.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_WRITE,
    ST_RESP
  } wtc_state_e;
endpackage

// File: rtl/wtc_match.sv
module wtc_match #(
  parameter int LINES = 2,
  parameter int TAG_W = 4,
  parameter int WAY_W = 1
) (
  input  logic [LINES-1:0]            valid_i,
  input  logic [LINES-1:0][TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0]            look_tag_i,
  output logic                        hit_o,
  output logic [WAY_W-1:0]            way_o
);
  logic [LINES-1:0] hit_vec;

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign hit_vec[g] = valid_i[g] && (tag_i[g] == look_tag_i);
  end

  always_comb begin
    hit_o = |hit_vec;
    way_o = '0;
    for (int i = 0; i < LINES; i++) begin
      if (hit_vec[i]) way_o = WAY_W'(i);
    end
  end
endmodule

// File: rtl/wtc_victim.sv
module wtc_victim #(
  parameter int LINES = 2,
  parameter int WAY_W = 1
) (
  input  logic [LINES-1:0] valid_i,
  input  logic [WAY_W-1:0] lru_i,
  output logic [WAY_W-1:0] victim_o
);
  // lowest-numbered free line wins; otherwise the least recently used one
  always_comb begin
    victim_o = lru_i;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (!valid_i[i]) victim_o = WAY_W'(i);
    end
  end
endmodule

// File: rtl/wtc_stats.sv
module wtc_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_i,
  input  logic             miss_i,
  output logic [CNT_W-1:0] hit_cnt_o,
  output logic [CNT_W-1:0] miss_cnt_o
);
  logic [CNT_W-1:0] hit_q, hit_d, miss_q, miss_d;
  logic             hit_en, miss_en;

  always_comb begin
    hit_en  = done_i && !miss_i;
    miss_en = done_i && miss_i;
    hit_d   = hit_q + CNT_W'(1);
    miss_d  = miss_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= '0;
      miss_q <= '0;
    end else begin
      if (hit_en)  hit_q  <= hit_d;
      if (miss_en) miss_q <= miss_d;
    end
  end

  assign hit_cnt_o  = hit_q;
  assign miss_cnt_o = miss_q;
endmodule

// File: rtl/wt_cache.sv
module wt_cache #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int OFF_W  = 1,
  parameter int CNT_W  = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cpu_req_valid,
  output logic                              cpu_req_ready,
  input  logic                              cpu_we,
  input  logic [ADDR_W-1:0]                 cpu_addr,
  input  logic [DATA_W-1:0]                 cpu_wdata,
  output logic                              cpu_rsp_valid,
  output logic [DATA_W-1:0]                 cpu_rdata,
  output logic                              mem_rd_valid,
  input  logic                              mem_rd_ready,
  output logic [ADDR_W-OFF_W-1:0]           mem_rd_addr,
  input  logic                              mem_rd_rvalid,
  input  logic [(1<<OFF_W)*DATA_W-1:0]      mem_rd_data,
  output logic                              mem_wr_valid,
  input  logic                              mem_wr_ready,
  output logic [ADDR_W-1:0]                 mem_wr_addr,
  output logic [DATA_W-1:0]                 mem_wr_data,
  output logic [CNT_W-1:0]                  hit_count,
  output logic [CNT_W-1:0]                  miss_count
);
  import wtc_pkg::*;

  localparam int LINES = 2;                 // single recency bit covers two lines
  localparam int WAY_W = 1;
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int ITEMS = 1 << OFF_W;
  localparam int BLK_W = ITEMS * DATA_W;

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  // state
  wtc_state_e                     state_q, state_d;
  logic [ADDR_W-1:0]              req_addr_q;
  logic                           req_we_q;
  logic [DATA_W-1:0]              req_wdata_q;
  logic                           req_load;
  logic                           miss_q, miss_d;
  logic [DATA_W-1:0]              rdata_q, rdata_d;
  logic                           rdata_en;
  logic [WAY_W-1:0]               lru_q, lru_d;
  logic [LINES-1:0]               line_valid_q, line_valid_d;
  logic [LINES-1:0][TAG_W-1:0]    line_tag_q, line_tag_d;
  logic [LINES-1:0][BLK_W-1:0]    line_data_q, line_data_d;
  logic                           line_en;

  logic [TAG_W-1:0]               req_tag;
  logic [OFF_W-1:0]               req_off;
  logic                           hit;
  logic [WAY_W-1:0]               hit_way, victim_way;

  assign req_tag = req_addr_q[ADDR_W-1:OFF_W];
  assign req_off = req_addr_q[OFF_W-1:0];

  wtc_match #(.LINES(LINES), .TAG_W(TAG_W), .WAY_W(WAY_W)) match_i (
    .valid_i    (line_valid_q),
    .tag_i      (line_tag_q),
    .look_tag_i (req_tag),
    .hit_o      (hit),
    .way_o      (hit_way)
  );

  wtc_victim #(.LINES(LINES), .WAY_W(WAY_W)) victim_i (
    .valid_i  (line_valid_q),
    .lru_i    (lru_q),
    .victim_o (victim_way)
  );

  // next-state logic
  always_comb begin
    state_d      = state_q;
    req_load     = 1'b0;
    miss_d       = miss_q;
    rdata_d      = rdata_q;
    rdata_en     = 1'b0;
    lru_d        = lru_q;
    line_valid_d = line_valid_q;
    line_tag_d   = line_tag_q;
    line_data_d  = line_data_q;
    line_en      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req_valid) begin
          req_load = 1'b1;
          miss_d   = 1'b0;
          state_d  = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (hit) begin
          lru_d    = hit_way ^ WAY_W'(1);
          rdata_en = 1'b1;
          if (req_we_q) begin
            line_en = 1'b1;
            line_data_d[hit_way][req_off*DATA_W +: DATA_W] = req_wdata_q;
            rdata_d = req_wdata_q;
            state_d = ST_WRITE;
          end else begin
            rdata_d = line_data_q[hit_way][req_off*DATA_W +: DATA_W];
            state_d = ST_RESP;
          end
        end else begin
          miss_d  = 1'b1;
          state_d = ST_FILL_REQ;
        end
      end
      ST_FILL_REQ: begin
        if (mem_rd_ready) state_d = ST_FILL_WAIT;
      end
      ST_FILL_WAIT: begin
        if (mem_rd_rvalid) begin
          line_en                  = 1'b1;
          line_valid_d[victim_way] = 1'b1;
          line_tag_d[victim_way]   = req_tag;
          line_data_d[victim_way]  = mem_rd_data;
          lru_d                    = victim_way ^ WAY_W'(1);
          state_d                  = ST_LOOKUP;
        end
      end
      ST_WRITE: begin
        if (mem_wr_ready) state_d = ST_RESP;
      end
      ST_RESP: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers with reset
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q      <= ST_IDLE;
      miss_q       <= 1'b0;
      lru_q        <= '0;
      line_valid_q <= '0;
    end else begin
      state_q <= state_d;
      miss_q  <= miss_d;
      lru_q   <= lru_d;
      if (line_en) line_valid_q <= line_valid_d;
    end
  end

  // datapath registers, no reset
  always_ff @(posedge clk) begin
    if (req_load) begin
      req_addr_q  <= cpu_addr;
      req_we_q    <= cpu_we;
      req_wdata_q <= cpu_wdata;
    end
    if (rdata_en) rdata_q <= rdata_d;
    if (line_en) begin
      line_tag_q  <= line_tag_d;
      line_data_q <= line_data_d;
    end
  end

  wtc_stats #(.CNT_W(CNT_W)) stats_i (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .done_i     (state_q == ST_RESP),
    .miss_i     (miss_q),
    .hit_cnt_o  (hit_count),
    .miss_cnt_o (miss_count)
  );

  assign cpu_req_ready = (state_q == ST_IDLE);
  assign cpu_rsp_valid = (state_q == ST_RESP);
  assign cpu_rdata     = rdata_q;
  assign mem_rd_valid  = (state_q == ST_FILL_REQ);
  assign mem_rd_addr   = req_tag;
  assign mem_wr_valid  = (state_q == ST_WRITE);
  assign mem_wr_addr   = req_addr_q;
  assign mem_wr_data   = req_wdata_q;
endmodule

// File: rtl/wt_cache_chk.sv
module wt_cache_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int OFF_W  = 1,
  parameter int CNT_W  = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cpu_req_ready,
  input logic                    cpu_rsp_valid,
  input logic                    mem_rd_valid,
  input logic                    mem_rd_ready,
  input logic [ADDR_W-OFF_W-1:0] mem_rd_addr,
  input logic                    mem_wr_valid,
  input logic                    mem_wr_ready,
  input logic [ADDR_W-1:0]       mem_wr_addr,
  input logic [DATA_W-1:0]       mem_wr_data,
  input logic [CNT_W-1:0]        hit_count,
  input logic [CNT_W-1:0]        miss_count,
  input logic                    req_we
);
  a_r3_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  a_r5_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  a_r6_write_only_for_store: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> req_we);

  a_r8_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=>
      (CNT_W'(hit_count + miss_count) == CNT_W'($past(hit_count) + $past(miss_count) + 1'b1)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rsp_valid |=> ($stable(hit_count) && $stable(miss_count)));

  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid || mem_wr_valid || cpu_rsp_valid) |-> !cpu_req_ready);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> !cpu_rsp_valid);
endmodule

bind wt_cache wt_cache_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .CNT_W(CNT_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_req_ready (cpu_req_ready),
  .cpu_rsp_valid (cpu_rsp_valid),
  .mem_rd_valid  (mem_rd_valid),
  .mem_rd_ready  (mem_rd_ready),
  .mem_rd_addr   (mem_rd_addr),
  .mem_wr_valid  (mem_wr_valid),
  .mem_wr_ready  (mem_wr_ready),
  .mem_wr_addr   (mem_wr_addr),
  .mem_wr_data   (mem_wr_data),
  .hit_count     (hit_count),
  .miss_count    (miss_count),
  .req_we        (req_we_q)
);

// File: tb/wt_cache_tb_top.sv
module wt_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req_valid, cpu_we;
  logic [4:0]  cpu_addr;
  logic [7:0]  cpu_wdata, cpu_rdata;
  logic        cpu_req_ready, cpu_rsp_valid;
  logic        mem_rd_valid, mem_rd_ready, mem_rd_rvalid;
  logic [3:0]  mem_rd_addr;
  logic [15:0] mem_rd_data;
  logic        mem_wr_valid, mem_wr_ready;
  logic [4:0]  mem_wr_addr;
  logic [7:0]  mem_wr_data;
  logic [15:0] hit_count, miss_count;

  always #5 clk = ~clk;

  wt_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rdata(cpu_rdata),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rd_rvalid(mem_rd_rvalid),
    .mem_rd_data(mem_rd_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  int checks = 0;
  int errors = 0;

  // backing memory and traffic log
  logic [7:0] ref_mem [32];
  int         fill_cnt = 0, wr_cnt = 0;
  logic [3:0] last_rd_addr;
  logic [4:0] last_wr_addr;
  logic [7:0] last_wr_data;
  bit         rd_pend = 0;
  int         rd_delay = 0;
  logic [3:0] rd_tag;

  // reference cache state
  bit         mv [2];
  logic [3:0] mt [2];
  int         mlru = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] block_of(input logic [3:0] t);
    return {ref_mem[{t, 1'b1}], ref_mem[{t, 1'b0}]};
  endfunction

  // memory model, driven away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rd_ready  = 1'b0;
      mem_rd_rvalid = 1'b0;
      mem_wr_ready  = 1'b0;
      rd_pend       = 0;
    end else begin
      mem_rd_rvalid = 1'b0;
      if (rd_pend) begin
        mem_rd_ready = 1'b0;
        if (rd_delay == 0) begin
          mem_rd_rvalid = 1'b1;
          mem_rd_data   = block_of(rd_tag);
          rd_pend       = 0;
        end else begin
          rd_delay--;
        end
      end else begin
        mem_rd_ready = 1'($urandom % 2);
        if (mem_rd_valid && mem_rd_ready) begin
          rd_pend      = 1;
          rd_delay     = int'($urandom % 3);
          rd_tag       = mem_rd_addr;
          last_rd_addr = mem_rd_addr;
          fill_cnt++;
        end
      end
      mem_wr_ready = 1'($urandom % 2);
      if (mem_wr_valid && mem_wr_ready) begin
        wr_cnt++;
        last_wr_addr = mem_wr_addr;
        last_wr_data = mem_wr_data;
        ref_mem[mem_wr_addr] = mem_wr_data;
      end
    end
  end

  task automatic do_access(input bit we, input logic [4:0] a, input logic [7:0] wd,
                           input string hit_req);
    bit exp_hit = 0;
    int way = 0;
    int f0, w0;
    logic [15:0] h0, m0;
    logic [7:0] exp_rd;
    bit saw_ready = 0;
    int guard = 0;
    for (int i = 0; i < 2; i++)
      if (mv[i] && mt[i] == a[4:1]) begin exp_hit = 1; way = i; end
    if (!exp_hit) begin
      way = !mv[0] ? 0 : (!mv[1] ? 1 : mlru);
      mv[way] = 1;
      mt[way] = a[4:1];
    end
    mlru = (way == 0) ? 1 : 0;
    h0 = hit_count; m0 = miss_count; f0 = fill_cnt; w0 = wr_cnt;
    cpu_req_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    while (!cpu_req_ready) @(negedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    while (!cpu_rsp_valid && guard < 200) begin
      if (cpu_req_ready) saw_ready = 1;
      guard++;
      @(negedge clk);
    end
    chk(!saw_ready && cpu_rsp_valid, "R9 busy/response", int'(saw_ready), 0);
    exp_rd = we ? wd : ref_mem[a];
    chk(cpu_rdata == exp_rd, we ? "R5 store echo" : "R10/R3 load data",
        int'(cpu_rdata), int'(exp_rd));
    @(negedge clk);
    chk(!cpu_rsp_valid, "R9 single pulse", int'(cpu_rsp_valid), 0);
    chk(hit_count == h0 + 16'(exp_hit), hit_req, int'(hit_count), int'(h0 + 16'(exp_hit)));
    chk(miss_count == m0 + 16'(!exp_hit), "R8 miss counter", int'(miss_count),
        int'(m0 + 16'(!exp_hit)));
    chk(fill_cnt - f0 == int'(!exp_hit), "R3/R10 block reads", fill_cnt - f0, int'(!exp_hit));
    if (!exp_hit) chk(last_rd_addr == a[4:1], "R3 block address", int'(last_rd_addr), int'(a[4:1]));
    chk(wr_cnt - w0 == int'(we), we ? "R5 one write" : "R6 no write on load",
        wr_cnt - w0, int'(we));
    if (we) chk(last_wr_addr == a && last_wr_data == wd, "R5 write addr/data",
                int'({last_wr_addr, last_wr_data}), int'({a, wd}));
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) ref_mem[i] = 8'($urandom);
    mv[0] = 0; mv[1] = 0;
    cpu_req_valid = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(cpu_req_ready == 1'b1, "R1 ready after reset", int'(cpu_req_ready), 1);
    chk(hit_count == 0 && miss_count == 0, "R1 counters zero",
        int'(hit_count) + int'(miss_count), 0);
    chk(!mem_rd_valid && !mem_wr_valid && !cpu_rsp_valid, "R1 idle outputs",
        int'({mem_rd_valid, mem_wr_valid, cpu_rsp_valid}), 0);
    // directed sequences
    do_access(0, 5'd1,  8'h00, "R1 first access misses");
    do_access(0, 5'd0,  8'h00, "R2 neighbour byte hits");
    do_access(1, 5'd7,  8'hA5, "R4 store miss allocates");
    do_access(0, 5'd6,  8'h00, "R4 allocated block hits");
    do_access(1, 5'd0,  8'h3C, "R5 store hit");
    do_access(0, 5'd0,  8'h00, "R5 load sees stored byte");
    do_access(0, 5'd10, 8'h00, "R7 evict least recent");
    do_access(0, 5'd1,  8'h00, "R7 recent line kept");
    do_access(0, 5'd6,  8'h00, "R7/R6 evicted line misses");
    // random traffic
    for (int n = 0; n < 400; n++)
      do_access(1'($urandom % 2), 5'($urandom % 32), 8'($urandom), "R7/R8 hit counter");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule